// File: doc/BRIEF.md
# Predicated Vector Compare-Against-Immediate Unit

This unit takes one vector value, a governing predicate, an element-size code, a comparison selector and a small immediate. It treats the vector as a row of equal-width integer lanes. Each lane that the governing predicate marks active is compared with the immediate, which is extended to the lane width. The unit returns a byte-granular destination predicate and four condition flags that summarise that predicate.

The unit sits after the decode stage of a vector pipeline. The register read has already taken place, so the governing predicate arrives on the port as a value. All outputs are registered and update one clock after the inputs are presented. The vector length is a parameter; the predicate has one bit for each vector byte.

Top module: `vcmp_imm_unit`

## Requirements
- R1: `elem_size` selects the lane width as 8 << elem_size (0: 8, 1: 16, 2: 32, 3: 64 bits). Lane e occupies `src_vec` bits starting at e·width.
- R2: `cmp_op` encodes 0 equal, 1 not equal, 2 greater-or-equal, 3 greater, 4 less, 5 less-or-equal. With `cmp_unsigned`=1, codes 2–5 compare as unsigned (higher-or-same, higher, lower, lower-or-same). For codes 0 and 1, `cmp_unsigned` has no effect.
- R3: Signed comparisons use `imm_field[4:0]` sign-extended to the lane width. Unsigned comparisons use `imm_field[6:0]` zero-extended. Equal and not-equal always use the signed form. Lane and immediate are compared at the full lane width.
- R4: The predicate is VLEN/8 bits wide. Lane e owns the group of width/8 bits starting at bit e·(width/8). A lane is active when `gov_pred` has a 1 at the lowest bit of its group. The other `gov_pred` bits of the group have no effect.
- R5: For an active lane, the comparison result is written to the lowest bit of its group, and the rest of the group is 0.
- R6: Every bit in the group of an inactive lane is 0 in `dst_pred`.
- R7: `flag_n` equals the result bit of the lowest-numbered active lane.
- R8: `flag_z` is 1 exactly when no active lane produced a true result.
- R9: `flag_c` is the inverse of the result bit of the highest-numbered active lane. `flag_v` is always 0.
- R10: When no lane is active, `dst_pred` is all zeros, with N=0, Z=1 and C=1.
- R11: `cmp_op` values 6 and 7 give an all-zero predicate, with N=0, Z=1 and C=1.
- R12: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, `dst_pred` is 0 and N=0, Z=1, C=1, V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vec | input | VLEN | Vector operand |
| gov_pred | input | VLEN/8 | Governing predicate, one bit per byte |
| elem_size | input | 2 | Lane width code |
| cmp_op | input | 3 | Comparison selector |
| cmp_unsigned | input | 1 | Selects unsigned ordering for ordered compares |
| imm_field | input | 7 | Immediate bits |
| dst_pred | output | VLEN/8 | Destination predicate |
| flag_n | output | 1 | First active lane true |
| flag_z | output | 1 | No active lane true |
| flag_c | output | 1 | Last active lane not true |
| flag_v | output | 1 | Always zero |

## Verification
The bench builds the unit with the default VLEN of 256. That gives a 32-bit predicate with 32, 16, 8 and 4 lanes for the four widths, so groups of one, two, four and eight predicate bits are all exercised. At this length random masks often leave only one or two lanes active, which separates the first-lane and last-lane flags. Lanes filled with the extended immediate and its two neighbours reach the equality and off-by-one boundaries. The sweep covers the immediate extremes −16, 15, 0 and 127 in every mode.

// File: rtl/vcmp_imm_pkg.sv
`timescale 1ns/1ps
package vcmp_imm_pkg;

  typedef enum logic [2:0] {
    OP_EQ = 3'd0,
    OP_NE = 3'd1,
    OP_GE = 3'd2,
    OP_GT = 3'd3,
    OP_LT = 3'd4,
    OP_LE = 3'd5
  } cmp_op_e;

  localparam int unsigned NUM_SIZES = 4;

  // Ordered compares may be unsigned; equality always uses the signed immediate.
  function automatic logic use_zero_ext(logic [2:0] op, logic uns);
    return uns && (op != OP_EQ) && (op != OP_NE);
  endfunction

  // Turns the equal and less-than relations into the selected outcome.
  function automatic logic decide(logic [2:0] op, logic eq, logic lt);
    case (op)
      OP_EQ:   return eq;
      OP_NE:   return !eq;
      OP_GE:   return !lt;
      OP_GT:   return !lt && !eq;
      OP_LT:   return lt;
      OP_LE:   return lt || eq;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vcmp_imm_lane.sv
`timescale 1ns/1ps
module vcmp_imm_lane #(
  parameter int unsigned EW = 8
) (
  input  logic [EW-1:0] elem,
  input  logic [6:0]    imm,
  input  logic [2:0]    op,
  input  logic          uns,
  output logic          hit
);
  import vcmp_imm_pkg::*;

  logic          zero_ext;
  logic [EW-1:0] imm_ew;
  logic          eq_w;
  logic          lt_w;

  assign zero_ext = use_zero_ext(op, uns);
  assign imm_ew   = zero_ext ? EW'(imm) : EW'($signed(imm[4:0]));
  assign eq_w     = (elem == imm_ew);
  assign lt_w     = zero_ext ? (elem < imm_ew) : ($signed(elem) < $signed(imm_ew));
  assign hit      = decide(op, eq_w, lt_w);

endmodule

// File: rtl/vcmp_imm_slice.sv
`timescale 1ns/1ps
module vcmp_imm_slice #(
  parameter int unsigned VLEN = 256,
  parameter int unsigned SZ   = 0
) (
  input  logic [VLEN-1:0]             src_vec,
  input  logic [VLEN/(8<<SZ)-1:0]     act,
  input  logic [2:0]                  op,
  input  logic                        uns,
  input  logic [6:0]                  imm,
  output logic [VLEN/8-1:0]           res,
  output logic [VLEN/8-1:0]           lead
);
  localparam int unsigned EW  = 8 << SZ;
  localparam int unsigned NEL = VLEN / EW;
  localparam int unsigned GB  = EW / 8;

  for (genvar e = 0; e < NEL; e++) begin : g_el
    logic hit;
    vcmp_imm_lane #(.EW(EW)) i_lane (
      .elem (src_vec[e*EW +: EW]),
      .imm  (imm),
      .op   (op),
      .uns  (uns),
      .hit  (hit)
    );
    assign res[e*GB]  = act[e] & hit;
    assign lead[e*GB] = act[e];
    if (GB > 1) begin : g_pad
      assign res[e*GB+1 +: GB-1]  = '0;
      assign lead[e*GB+1 +: GB-1] = '0;
    end
  end

endmodule

// File: rtl/vcmp_imm_flags.sv
`timescale 1ns/1ps
module vcmp_imm_flags #(
  parameter int unsigned PW = 32
) (
  input  logic [PW-1:0] result,
  input  logic [PW-1:0] lead,
  output logic          n_out,
  output logic          z_out,
  output logic          c_out,
  output logic          any_act
);
  logic seen;

  always_comb begin
    n_out = 1'b0;
    c_out = 1'b1;
    seen  = 1'b0;
    for (int i = 0; i < PW; i++) begin
      if (lead[i]) begin
        if (!seen) n_out = result[i];
        seen  = 1'b1;
        c_out = !result[i];
      end
    end
  end

  assign z_out   = ~|result;
  assign any_act = |lead;

endmodule

// File: rtl/vcmp_imm_unit.sv
`timescale 1ns/1ps
module vcmp_imm_unit #(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN/8-1:0] gov_pred,
  input  logic [1:0]        elem_size,
  input  logic [2:0]        cmp_op,
  input  logic              cmp_unsigned,
  input  logic [6:0]        imm_field,
  output logic [VLEN/8-1:0] dst_pred,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  import vcmp_imm_pkg::*;

  localparam int unsigned PW = VLEN / 8;

  logic [PW-1:0] res_by_size  [NUM_SIZES];
  logic [PW-1:0] lead_by_size [NUM_SIZES];

  // Named internal events used by the checker
  logic [PW-1:0] cmp_pred;
  logic [PW-1:0] act_lead;
  logic          any_active;
  logic          n_next, z_next, c_next;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned EW  = 8 << s;
    localparam int unsigned NEL = VLEN / EW;
    localparam int unsigned GB  = EW / 8;
    logic [NEL-1:0] act;
    for (genvar e = 0; e < NEL; e++) begin : g_act
      assign act[e] = gov_pred[e*GB];
    end
    vcmp_imm_slice #(.VLEN(VLEN), .SZ(s)) i_slice (
      .src_vec (src_vec),
      .act     (act),
      .op      (cmp_op),
      .uns     (cmp_unsigned),
      .imm     (imm_field),
      .res     (res_by_size[s]),
      .lead    (lead_by_size[s])
    );
  end

  assign cmp_pred = res_by_size[elem_size];
  assign act_lead = lead_by_size[elem_size];

  vcmp_imm_flags #(.PW(PW)) i_flags (
    .result  (cmp_pred),
    .lead    (act_lead),
    .n_out   (n_next),
    .z_out   (z_next),
    .c_out   (c_next),
    .any_act (any_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_pred <= '0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b1;
      flag_c   <= 1'b1;
      flag_v   <= 1'b0;
    end else begin
      dst_pred <= cmp_pred;
      flag_n   <= n_next;
      flag_z   <= z_next;
      flag_c   <= c_next;
      flag_v   <= 1'b0;
    end
  end

endmodule

// File: rtl/vcmp_imm_checker.sv
`timescale 1ns/1ps
module vcmp_imm_checker #(
  parameter int unsigned PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    elem_size,
  input logic [2:0]    cmp_op,
  input logic [PW-1:0] act_lead,
  input logic          any_active,
  input logic [PW-1:0] dst_pred,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_c
);

  function automatic logic [PW-1:0] group_starts(logic [1:0] sz);
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = ((i % (1 << sz)) == 0);
    return m;
  endfunction

  assert_low_bit_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dst_pred & ~group_starts($past(elem_size))) == '0));

  assert_inactive_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dst_pred & ~$past(act_lead)) == '0));

  assert_n_implies_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_n |-> (dst_pred != '0));

  assert_zero_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z == (dst_pred == '0));

  assert_carry_low_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_c |-> (dst_pred != '0));

  assert_no_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |=> (dst_pred == '0 && !flag_n && flag_z && flag_c));

  assert_unused_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_op > 3'd5) |=> (dst_pred == '0 && !flag_n && flag_z && flag_c));

endmodule

bind vcmp_imm_unit vcmp_imm_checker #(.PW(PW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .elem_size  (elem_size),
  .cmp_op     (cmp_op),
  .act_lead   (act_lead),
  .any_active (any_active),
  .dst_pred   (dst_pred),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c)
);

// File: tb/test_vcmp_imm_unit.sv
`timescale 1ns/1ps
module test_vcmp_imm_unit;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [VLEN-1:0] src_vec = '0;
  logic [PW-1:0]   gov_pred = '0;
  logic [1:0]      elem_size = '0;
  logic [2:0]      cmp_op = '0;
  logic            cmp_unsigned = 1'b0;
  logic [6:0]      imm_field = '0;
  logic [PW-1:0]   dst_pred;
  logic            flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vcmp_imm_unit #(.VLEN(VLEN)) i_vcmp_imm_unit (
    .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .gov_pred(gov_pred),
    .elem_size(elem_size), .cmp_op(cmp_op), .cmp_unsigned(cmp_unsigned),
    .imm_field(imm_field), .dst_pred(dst_pred), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic [2:0]  op;
    logic        uns;
    logic [6:0]  imm;
    logic [63:0] fill;
    logic [31:0] mask;
  } vec_t;

  localparam int NTAB = 14;
  localparam vec_t TAB [NTAB] = '{
    '{2'd0, 3'd0, 1'b0, 7'h05, 64'h0505_0605_0405_05FF, 32'hFFFF_FFFF},
    '{2'd0, 3'd1, 1'b1, 7'h1F, 64'hFFFF_00FF_FE01_FF7F, 32'hFFFF_FFFF},
    '{2'd1, 3'd2, 1'b0, 7'h10, 64'hFFF0_FFEF_0000_8000, 32'h5555_5555},
    '{2'd1, 3'd3, 1'b1, 7'h7F, 64'h0080_007F_FFFF_0000, 32'h5555_5555},
    '{2'd2, 3'd4, 1'b0, 7'h0F, 64'h0000_000E_8000_0000, 32'h1111_1111},
    '{2'd2, 3'd5, 1'b1, 7'h00, 64'h0000_0000_0000_0001, 32'h1111_1111},
    '{2'd3, 3'd2, 1'b1, 7'h40, 64'h0000_0000_0000_0040, 32'h0101_0101},
    '{2'd3, 3'd4, 1'b0, 7'h10, 64'hFFFF_FFFF_FFFF_FFEF, 32'h0101_0101},
    '{2'd3, 3'd0, 1'b1, 7'h7F, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0101_0101},
    '{2'd0, 3'd5, 1'b0, 7'h00, 64'h8001_7F00_FF80_0102, 32'hA5A5_0F0F},
    '{2'd1, 3'd0, 1'b0, 7'h03, 64'h0003_0300_0003_0103, 32'hFEFE_FEFE},
    '{2'd3, 3'd0, 1'b0, 7'h00, 64'h0000_0000_0000_0000, 32'hFEFE_FEFE},
    '{2'd2, 3'd6, 1'b0, 7'h00, 64'h0000_0001_0000_0000, 32'hFFFF_FFFF},
    '{2'd0, 3'd7, 1'b1, 7'h7F, 64'h7F7F_7F7F_7F7F_7F7F, 32'hFFFF_FFFF}
  };

  // Behavioural loop model written from the requirements
  function automatic void ref_model(input logic [VLEN-1:0] v, input logic [PW-1:0] g,
                                    input logic [1:0] sz, input logic [2:0] op,
                                    input logic uns, input logic [6:0] imm,
                                    output logic [PW-1:0] p, output logic n,
                                    output logic z, output logic c);
    int ew = 8 << sz;
    int gb = ew / 8;
    int nel = VLEN / ew;
    bit first = 1'b1;
    bit zx = uns && (op >= 3'd2);
    logic [63:0] msk = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    logic [63:0] imm64 = zx ? {57'd0, imm} : {{59{imm[4]}}, imm[4:0]};
    p = '0; n = 1'b0; z = 1'b1; c = 1'b1;
    for (int e = 0; e < nel; e++) begin
      logic [63:0] a = (64'(v >> (e * ew))) & msk;
      logic [63:0] b = imm64 & msk;
      longint sa = longint'(a << (64 - ew)) >>> (64 - ew);
      longint sb = longint'(b << (64 - ew)) >>> (64 - ew);
      bit eq = (a == b);
      bit lt = zx ? (a < b) : (sa < sb);
      bit r;
      case (op)
        3'd0: r = eq;
        3'd1: r = !eq;
        3'd2: r = !lt;
        3'd3: r = !lt && !eq;
        3'd4: r = lt;
        3'd5: r = lt || eq;
        default: r = 1'b0;
      endcase
      if (g[e * gb]) begin
        p[e * gb] = r;
        if (first) n = r;
        first = 1'b0;
        c = !r;
        if (r) z = 1'b0;
      end
    end
  endfunction

  task automatic check_out(input string tag, input logic [PW-1:0] ep,
                           input logic en, input logic ez, input logic ec);
    checks++;
    if (dst_pred !== ep || flag_n !== en || flag_z !== ez || flag_c !== ec || flag_v !== 1'b0) begin
      errors++;
      $display("FAIL %s: got pred=%h n=%b z=%b c=%b v=%b, expected pred=%h n=%b z=%b c=%b v=0",
               tag, dst_pred, flag_n, flag_z, flag_c, flag_v, ep, en, ez, ec);
    end
  endtask

  logic [PW-1:0] last_p;
  logic last_n, last_z, last_c;

  task automatic run_one(input string tag, input logic [VLEN-1:0] v, input logic [PW-1:0] g,
                         input logic [1:0] sz, input logic [2:0] op, input logic uns,
                         input logic [6:0] imm);
    @(negedge clk);
    src_vec = v; gov_pred = g; elem_size = sz; cmp_op = op; cmp_unsigned = uns; imm_field = imm;
    ref_model(v, g, sz, op, uns, imm, last_p, last_n, last_z, last_c);
    @(posedge clk);
    #1;
    check_out(tag, last_p, last_n, last_z, last_c);
  endtask

  function automatic logic [VLEN-1:0] build_vec(input logic [1:0] sz, input logic [2:0] op,
                                                input logic uns, input logic [6:0] imm);
    logic [VLEN-1:0] v = '0;
    int ew = 8 << sz;
    bit zx = uns && (op >= 3'd2);
    logic [63:0] base = zx ? {57'd0, imm} : {{59{imm[4]}}, imm[4:0]};
    for (int e = 0; e < VLEN / ew; e++) begin
      logic [63:0] val;
      case (e % 4)
        0: val = base;
        1: val = base + 64'd1;
        2: val = base - 64'd1;
        default: val = {$urandom, $urandom};
      endcase
      for (int b = 0; b < ew; b++) v[e * ew + b] = val[b];
    end
    return v;
  endfunction

  initial begin : watchdog
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [6:0] imms [4] = '{7'h10, 7'h0F, 7'h00, 7'h7F};
    // R12: reset state
    #3;
    check_out("R12 reset", '0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R4 R5 R7 R8 R9, plus R10 (entry 11) and R11 (entries 12, 13)
    for (int i = 0; i < NTAB; i++) begin
      run_one("R1 R2 R3 R4 R5 R7 R8 R9 R10 R11 table", {4{TAB[i].fill}}, TAB[i].mask,
              TAB[i].sz, TAB[i].op, TAB[i].uns, TAB[i].imm);
    end

    // R4: non-lead governing bits alone activate nothing at doubleword width
    run_one("R4 non-lead bits", {4{64'h0}}, 32'hFEFE_FEFE, 2'd3, 3'd0, 1'b0, 7'h00);
    // R6: only lane 1 of 16-bit lanes active, every lane true
    run_one("R6 inactive lanes", {16{16'h0007}}, 32'h0000_0004, 2'd1, 3'd0, 1'b0, 7'h07);
    // R7 R9: single active lane at the top, true
    run_one("R7 R9 single top lane", {32{8'h01}}, 32'h8000_0000, 2'd0, 3'd3, 1'b0, 7'h00);
    // R10: empty mask with a vector that would otherwise match
    run_one("R10 empty mask", {32{8'h00}}, 32'h0000_0000, 2'd0, 3'd0, 1'b0, 7'h00);

    // R12: registered timing, output holds until the next edge
    run_one("R12 load", {32{8'h05}}, 32'hFFFF_FFFF, 2'd0, 3'd0, 1'b0, 7'h05);
    @(negedge clk);
    gov_pred = '0;
    #1;
    check_out("R12 hold before edge", last_p, last_n, last_z, last_c);
    @(posedge clk);
    #1;
    check_out("R12 update after edge", '0, 1'b0, 1'b1, 1'b1);

    // Sweep: R1 R2 R3 across sizes, codes, signedness and immediate extremes
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        for (int u = 0; u < 2; u++)
          for (int k = 0; k < 4; k++) begin
            logic [VLEN-1:0] v = build_vec(2'(s), 3'(o), 1'(u), imms[k]);
            run_one("R1 R2 R3 sweep", v, PW'($urandom), 2'(s), 3'(o), 1'(u), imms[k]);
          end

    // R12: reset in mid-run clears outputs
    run_one("R12 pre-reset", {32{8'h00}}, 32'hFFFF_FFFF, 2'd0, 3'd0, 1'b0, 7'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out("R12 mid-run reset", '0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule